// File: doc/BRIEF.md
# Register-Write Command Ring Engine

This block drains a circular command ring that software fills in shared memory and turns the packets it finds there into register writes. Software sets where the ring starts, how large it is, and how far it has been filled. The engine fetches one 16-bit word per cycle from its own read position toward that fill mark. It wraps at the end of the ring and emits a register-write strobe for every data word of a burst packet.

A burst packet starts with a header word that has bit 15 set and the target register base in bits [14:0]. Next comes a word that gives how many data words follow. The data words go to consecutive register addresses. Packets always span a multiple of four bytes, so a burst with an odd word count carries one trailing pad word, which the engine discards. A pair of all-zero words is a filler packet and is also discarded.

A 16-bit host register file gives access to the ring geometry, the two pointers, a run enable, status, and a pending/enable/force/acknowledge set for the completion interrupt.

Top module: `regq_engine`

## Requirements
- R1: After reset, both pointers read 0, STATUS (offset 8) reads 0x000C (bit 2 idle and bit 3 healthy both 1), the interrupt output is low, and no register write is issued.
- R2: A header word with bit 15 set latches bits [14:0] as register base. The next word is the data count N. The N following words are written to base, base+1, ... in order. N = 0 consumes only the two words.
- R3: When N is odd, the word after the last data word is a pad word. It is consumed and not written.
- R4: A 0x0000, 0x0000 word pair is consumed and produces no register write.
- R5: The byte write pointer is split into WR_LO (offset 5) and WR_HI (offset 6, bits [2:0] significant). A WR_HI write is only staged. A WR_LO write commits {staged high, low}. Reading WR_HI returns the committed bits [2:0].
- R6: The ring holds (LEN+1)*1024 bytes, where LEN is at offset 2. The read pointer goes from the last word back to byte offset 0.
- R7: STATUS bit 2 is 1 exactly when the read pointer equals the committed write pointer and no register write is pending. STATUS bit 3 is 1 until a decode failure.
- R8: A header word with bit 15 clear and a nonzero value clears STATUS bit 3. It halts fetching with the read pointer left on that word until reset.
- R9: The engine becoming idle sets interrupt pending (IRQ_PEND, offset 12, bit 0), as does writing bit 0 to IRQ_SET (offset 10). Writing bit 0 to IRQ_CLR (offset 11) clears it. When a set and a clear fall in the same cycle, the set wins. The irq output is pending AND IRQ_EN (offset 9) bit 0.
- R10: With CTRL (offset 7) bit 0 clear, no word is fetched and the read pointer holds.
- R11: The byte read pointer (RD_LO at offset 3, RD_HI at offset 4) advances by 2 for every word consumed, and ends equal to the write pointer once the ring is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Host register offset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data for hostAddr (combinational) |
| memAddr | output | 22 | Word address of the ring word being fetched |
| memRdData | input | 16 | Ring word at memAddr (same-cycle read) |
| regWrValid | output | 1 | Register write strobe |
| regWrAddr | output | 15 | Register write address |
| regWrData | output | 16 | Register write data |
| irq | output | 1 | Completion interrupt |

## Verification
The completion event that sets interrupt pending and a host acknowledge write to IRQ_CLR can land on the same clock edge. The bench provokes this by draining a packet while polling STATUS at each falling edge. In the same half-cycle where it first sees idle, it drives the clear, so the clear lands exactly on the edge where the completion is recorded. It then judges that pending and the irq output are still 1, because the new event must not be lost to an acknowledge meant for an older one.

// File: rtl/regq_pkg.sv
package regq_pkg;

  typedef enum logic [3:0] {
    HR_BASE_LO  = 4'd0,
    HR_BASE_HI  = 4'd1,
    HR_LEN      = 4'd2,
    HR_RD_LO    = 4'd3,
    HR_RD_HI    = 4'd4,
    HR_WR_LO    = 4'd5,
    HR_WR_HI    = 4'd6,
    HR_CTRL     = 4'd7,
    HR_STATUS   = 4'd8,
    HR_IRQ_EN   = 4'd9,
    HR_IRQ_SET  = 4'd10,
    HR_IRQ_CLR  = 4'd11,
    HR_IRQ_PEND = 4'd12
  } hostReg_e;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_CNT,
    ST_DATA,
    ST_PAD,
    ST_NOP,
    ST_HALT
  } fetchState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic consume;
    logic takeHeader;
    logic takeCount;
    logic emit;
    logic fault;
  } strobe_t;

  localparam int STAT_IDLE_BIT = 2;
  localparam int STAT_OK_BIT   = 3;
  localparam int KIB_WORD_SHIFT = 9;  // 1 KiB = 512 words

endpackage

// File: rtl/regq_ctrl.sv
module regq_ctrl
  import regq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        avail,
  input  logic [15:0] word,
  input  logic        cntOne,
  input  logic        cntOdd,
  output strobe_t     strb
);

  fetchState_e stateQ, stateD;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_HDR: if (avail) begin
        if (word[15]) begin
          strb.consume    = 1'b1;
          strb.takeHeader = 1'b1;
          stateD          = ST_CNT;
        end else if (word == 16'h0000) begin
          strb.consume = 1'b1;
          stateD       = ST_NOP;
        end else begin
          strb.fault = 1'b1;
          stateD     = ST_HALT;
        end
      end
      ST_NOP: if (avail) begin
        strb.consume = 1'b1;
        stateD       = ST_HDR;
      end
      ST_CNT: if (avail) begin
        strb.consume   = 1'b1;
        strb.takeCount = 1'b1;
        stateD         = (word == 16'h0000) ? ST_HDR : ST_DATA;
      end
      ST_DATA: if (avail) begin
        strb.consume = 1'b1;
        strb.emit    = 1'b1;
        if (cntOne) stateD = cntOdd ? ST_PAD : ST_HDR;
      end
      ST_PAD: if (avail) begin
        strb.consume = 1'b1;
        stateD       = ST_HDR;
      end
      ST_HALT: stateD = ST_HALT;
      default: stateD = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_HDR;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/regq_datapath.sv
module regq_datapath
  import regq_pkg::*;
#(
  parameter int PTR_W  = 19,
  parameter int BASE_W = 23,
  parameter int LEN_W  = 9,
  parameter int REG_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  output logic [BASE_W-2:0] memAddr,
  input  logic [15:0]       memRdData,
  output logic              regWrValid,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [15:0]       regWrData,
  output logic              irq,
  input  strobe_t           strb,
  output logic              avail,
  output logic [15:0]       word,
  output logic              cntOne,
  output logic              cntOdd,
  output logic [PTR_W-2:0]  rdWord,
  output logic [LEN_W-1:0]  lenQ,
  output logic              faultQ,
  output logic              runEn
);

  localparam int WP_W  = PTR_W - 1;   // pointers kept in words
  localparam int HI_W  = PTR_W - 16;  // significant high-half bits
  localparam int BHI_W = BASE_W - 16;

  logic [BASE_W-2:0] baseQ;
  logic [WP_W-1:0]   wrWord;
  logic [HI_W-1:0]   wrHiStage;
  logic              irqEn, irqPend, idlePrev, idle;
  logic [REG_AW-1:0] regBase;
  logic [15:0]       remain;
  logic [WP_W-1:0]   rdNext;
  logic              atWrap, setEvt, clrEvt;
  hostReg_e          hReg;

  assign hReg   = hostReg_e'(hostAddr);
  assign word   = memRdData;
  assign memAddr = baseQ + (BASE_W-1)'(rdWord);
  assign avail  = runEn && (rdWord != wrWord);
  assign cntOne = (remain == 16'd1);
  assign idle   = (rdWord == wrWord) && !regWrValid;
  assign rdNext = rdWord + 1'b1;
  assign atWrap = (32'(rdNext) == ((32'(lenQ) + 32'd1) << KIB_WORD_SHIFT));
  assign setEvt = (idle && !idlePrev) ||
                  (hostWrEn && hReg == HR_IRQ_SET && hostWrData[0]);
  assign clrEvt = hostWrEn && hReg == HR_IRQ_CLR && hostWrData[0];
  assign irq    = irqPend && irqEn;

  // host-visible configuration and write-pointer commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      lenQ      <= '0;
      wrWord    <= '0;
      wrHiStage <= '0;
      runEn     <= 1'b0;
      irqEn     <= 1'b0;
    end else if (hostWrEn) begin
      unique case (hReg)
        HR_BASE_LO: baseQ[14:0]         <= hostWrData[15:1];
        HR_BASE_HI: baseQ[BASE_W-2:15]  <= hostWrData[BHI_W-1:0];
        HR_LEN:     lenQ                <= hostWrData[LEN_W-1:0];
        HR_WR_HI:   wrHiStage           <= hostWrData[HI_W-1:0];
        HR_WR_LO:   wrWord              <= {wrHiStage, hostWrData[15:1]};
        HR_CTRL:    runEn               <= hostWrData[0];
        HR_IRQ_EN:  irqEn               <= hostWrData[0];
        default: ;
      endcase
    end
  end

  // read pointer, packet latches and register-write stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWord     <= '0;
      regBase    <= '0;
      remain     <= '0;
      cntOdd     <= 1'b0;
      regWrValid <= 1'b0;
      regWrAddr  <= '0;
      regWrData  <= '0;
      faultQ     <= 1'b0;
    end else begin
      regWrValid <= strb.emit;
      if (strb.consume)    rdWord  <= atWrap ? '0 : rdNext;
      if (strb.takeHeader) regBase <= word[REG_AW-1:0];
      if (strb.takeCount) begin
        remain <= word;
        cntOdd <= word[0];
      end
      if (strb.emit) begin
        regWrAddr <= regBase;
        regWrData <= word;
        regBase   <= regBase + 1'b1;
        remain    <= remain - 16'd1;
      end
      if (strb.fault) faultQ <= 1'b1;
    end
  end

  // completion interrupt: a new event beats an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend  <= 1'b0;
      idlePrev <= 1'b1;
    end else begin
      idlePrev <= idle;
      if (setEvt)      irqPend <= 1'b1;
      else if (clrEvt) irqPend <= 1'b0;
    end
  end

  always_comb begin
    hostRdData = '0;
    unique case (hReg)
      HR_BASE_LO:  hostRdData = {baseQ[14:0], 1'b0};
      HR_BASE_HI:  hostRdData = 16'(baseQ[BASE_W-2:15]);
      HR_LEN:      hostRdData = 16'(lenQ);
      HR_RD_LO:    hostRdData = {rdWord[14:0], 1'b0};
      HR_RD_HI:    hostRdData = 16'(rdWord[WP_W-1:15]);
      HR_WR_LO:    hostRdData = {wrWord[14:0], 1'b0};
      HR_WR_HI:    hostRdData = 16'(wrWord[WP_W-1:15]);
      HR_CTRL:     hostRdData = 16'(runEn);
      HR_STATUS: begin
        hostRdData[STAT_IDLE_BIT] = idle;
        hostRdData[STAT_OK_BIT]   = !faultQ;
      end
      HR_IRQ_EN:   hostRdData = 16'(irqEn);
      HR_IRQ_PEND: hostRdData = 16'(irqPend);
      default:     hostRdData = '0;
    endcase
  end

endmodule

// File: rtl/regq_engine.sv
module regq_engine
  import regq_pkg::*;
#(
  parameter int PTR_W  = 19,
  parameter int BASE_W = 23,
  parameter int LEN_W  = 9,
  parameter int REG_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  output logic [BASE_W-2:0] memAddr,
  input  logic [15:0]       memRdData,
  output logic              regWrValid,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [15:0]       regWrData,
  output logic              irq
);

  strobe_t          strb;
  logic             avail, cntOne, cntOdd, faultQ, runEn;
  logic [15:0]      word;
  logic [PTR_W-2:0] rdWord;
  logic [LEN_W-1:0] lenQ;

  regq_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .avail  (avail),
    .word   (word),
    .cntOne (cntOne),
    .cntOdd (cntOdd),
    .strb   (strb)
  );

  regq_datapath #(
    .PTR_W  (PTR_W),
    .BASE_W (BASE_W),
    .LEN_W  (LEN_W),
    .REG_AW (REG_AW)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .memAddr    (memAddr),
    .memRdData  (memRdData),
    .regWrValid (regWrValid),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .irq        (irq),
    .strb       (strb),
    .avail      (avail),
    .word       (word),
    .cntOne     (cntOne),
    .cntOdd     (cntOdd),
    .rdWord     (rdWord),
    .lenQ       (lenQ),
    .faultQ     (faultQ),
    .runEn      (runEn)
  );

endmodule

// File: rtl/regq_checker.sv
module regq_checker #(
  parameter int WP_W   = 18,
  parameter int LEN_W  = 9,
  parameter int REG_AW = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrValid,
  input logic [REG_AW-1:0] regWrAddr,
  input logic [WP_W-1:0]   rdWord,
  input logic [LEN_W-1:0]  lenQ,
  input logic              faultQ,
  input logic              runEn
);

  // R2: back-to-back writes belong to one burst and step the address
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid && $past(regWrValid) |-> regWrAddr == $past(regWrAddr) + 1'b1);

  // R11: the read pointer moves by one word or returns to zero
  a_r11_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdWord != $past(rdWord)) |-> (rdWord == $past(rdWord) + 1'b1) || (rdWord == '0));

  // R6: a return to zero happens only from the last word of the ring
  a_r6_wrap_point: assert property (@(posedge clk) disable iff (!rstN)
    (rdWord == '0 && $past(rdWord) != '0) |->
      (32'($past(rdWord)) + 32'd1 == ((32'($past(lenQ)) + 32'd1) << 9)));

  // R8: a decode failure is sticky
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |=> faultQ);

  // R8: nothing is consumed once failed
  a_r8_halt_still: assert property (@(posedge clk) disable iff (!rstN)
    (rdWord != $past(rdWord)) |-> !$past(faultQ));

  // R10: nothing is consumed while stopped
  a_r10_run_gate: assert property (@(posedge clk) disable iff (!rstN)
    (rdWord != $past(rdWord)) |-> $past(runEn));

endmodule

bind regq_engine regq_checker #(
  .WP_W   (PTR_W - 1),
  .LEN_W  (LEN_W),
  .REG_AW (REG_AW)
) i_regqChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrValid (regWrValid),
  .regWrAddr  (regWrAddr),
  .rdWord     (rdWord),
  .lenQ       (lenQ),
  .faultQ     (faultQ),
  .runEn      (runEn)
);

// File: tb/test_regq_engine.sv
`timescale 1ns/1ps
module test_regq_engine;

  localparam int RING_BYTES = 1024;
  localparam int BASE_BYTE  = 'h400;
  localparam int A_LEN = 2, A_RD_LO = 3, A_WR_LO = 5, A_WR_HI = 6, A_CTRL = 7,
                 A_STATUS = 8, A_IRQ_EN = 9, A_IRQ_SET = 10, A_IRQ_CLR = 11,
                 A_IRQ_PEND = 12, A_BASE_LO = 0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic [21:0] memAddr;
  logic [15:0] memRdData;
  logic        regWrValid;
  logic [14:0] regWrAddr;
  logic [15:0] regWrData;
  logic        irq;

  logic [15:0] mem [0:4095];
  logic [31:0] expQ [$];
  int checks = 0;
  int errors = 0;
  int wrOff = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign memRdData = mem[memAddr[11:0]];

  regq_engine i_regq_engine (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .memAddr(memAddr),
    .memRdData(memRdData), .regWrValid(regWrValid), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && regWrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected register write", int'(regWrAddr), -1);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check({1'b0, regWrAddr} == e[31:16] && regWrData == e[15:0], "R2",
              "register write {addr,data}", int'({1'b0, regWrAddr, regWrData}), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      summary();
    end
  end

  task automatic hostWrite(input int a, input int d);
    @(negedge clk);
    hostAddr = 4'(a); hostWrData = 16'(d); hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input int a, output int d);
    hostAddr = 4'(a);
    #1;
    d = int'(hostRdData);
  endtask

  task automatic putWord(input int off, input logic [15:0] w);
    int idx;
    idx = (BASE_BYTE + (off % RING_BYTES)) / 2;
    mem[idx] = w;
  endtask

  task automatic emitWord(input logic [15:0] w);
    putWord(wrOff, w);
    wrOff = (wrOff + 2) % RING_BYTES;
  endtask

  task automatic pushBurst(input int base, input int cnt, input int seed);
    emitWord(16'h8000 | 16'(base));
    emitWord(16'(cnt));
    for (int i = 0; i < cnt; i++) begin
      logic [15:0] d;
      d = 16'(seed + i * 7);
      emitWord(d);
      expQ.push_back({16'(base + i), d});
    end
    if (cnt % 2 == 1) emitWord(16'h0000);
  endtask

  task automatic commit();
    hostWrite(A_WR_HI, 0);
    hostWrite(A_WR_LO, wrOff);
  endtask

  task automatic waitIdle(input string req);
    int s;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      hostRead(A_STATUS, s);
      if (s[2]) return;
    end
    check(1'b0, req, "engine never idle", 0, 1);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    wrOff = 0;
    expQ.delete();
  endtask

  initial begin
    int v;
    int rdBefore;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    doReset();

    // R1 reset state
    @(negedge clk);
    hostRead(A_RD_LO, v);  check(v == 0, "R1", "RD_LO", v, 0);
    hostRead(A_WR_LO, v);  check(v == 0, "R1", "WR_LO", v, 0);
    hostRead(A_STATUS, v); check(v == 'hC, "R1", "STATUS", v, 'hC);
    check(irq == 1'b0, "R1", "irq", int'(irq), 0);

    hostWrite(A_BASE_LO, BASE_BYTE);
    hostWrite(A_LEN, 0);
    hostWrite(A_IRQ_EN, 1);
    hostWrite(A_CTRL, 1);

    // R2 plain burst and zero-count burst
    pushBurst('h0100, 4, 'h1000);
    pushBurst('h0200, 0, 0);
    commit();
    waitIdle("R2");
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2", "writes left", expQ.size(), 0);
    hostRead(A_RD_LO, v); check(v == wrOff, "R11", "RD_LO after drain", v, wrOff);
    check(irq == 1'b1, "R9", "irq after drain", int'(irq), 1);
    hostWrite(A_IRQ_CLR, 1);
    check(irq == 1'b0, "R9", "irq after clear", int'(irq), 0);

    // R3 odd count with pad
    pushBurst('h0300, 3, 'h2000);
    commit();
    waitIdle("R3");
    check(expQ.size() == 0, "R3", "writes left", expQ.size(), 0);
    hostRead(A_RD_LO, v); check(v == wrOff, "R3", "RD_LO past pad", v, wrOff);

    // R4 filler pair then a burst
    emitWord(16'h0000); emitWord(16'h0000);
    pushBurst('h0400, 2, 'h3000);
    commit();
    waitIdle("R4");
    check(expQ.size() == 0, "R4", "writes left", expQ.size(), 0);
    hostRead(A_RD_LO, v); check(v == wrOff, "R4", "RD_LO", v, wrOff);

    // R5 high half alone does not commit
    hostRead(A_RD_LO, rdBefore);
    pushBurst('h0500, 2, 'h4000);
    hostWrite(A_WR_HI, 5);
    repeat (10) @(negedge clk);
    hostRead(A_RD_LO, v); check(v == rdBefore, "R5", "RD_LO after high-only", v, rdBefore);
    hostRead(A_WR_HI, v); check(v == 0, "R5", "WR_HI readback", v, 0);
    hostRead(A_STATUS, v); check(v[2] == 1'b1, "R5", "still idle", v, 'hC);
    commit();
    waitIdle("R5");
    check(expQ.size() == 0, "R5", "writes left", expQ.size(), 0);

    // R9 force, enable gating, set wins over clear
    repeat (3) @(negedge clk);
    hostWrite(A_IRQ_CLR, 1);
    hostWrite(A_IRQ_SET, 1);
    check(irq == 1'b1, "R9", "irq after force", int'(irq), 1);
    hostWrite(A_IRQ_EN, 0);
    check(irq == 1'b0, "R9", "irq masked", int'(irq), 0);
    hostRead(A_IRQ_PEND, v); check(v == 1, "R9", "pending while masked", v, 1);
    hostWrite(A_IRQ_EN, 1);
    hostWrite(A_IRQ_CLR, 1);
    pushBurst('h0600, 2, 'h5000);
    commit();
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 4000 && !seen; i++) begin
        @(negedge clk);
        hostRead(A_STATUS, v);
        if (v[2]) begin
          seen = 1;
          hostAddr = 4'(A_IRQ_CLR); hostWrData = 16'h0001; hostWrEn = 1'b1;
          @(negedge clk);
          hostWrEn = 1'b0;
        end
      end
      check(seen, "R9", "idle seen", int'(seen), 1);
    end
    check(irq == 1'b1, "R9", "set wins over same-cycle clear", int'(irq), 1);
    hostWrite(A_IRQ_CLR, 1);

    // R6 wrap across the ring end
    pushBurst('h0700, (RING_BYTES - wrOff) / 2 + 1, 'h6000);
    commit();
    waitIdle("R6");
    check(expQ.size() == 0, "R6", "writes left", expQ.size(), 0);
    hostRead(A_RD_LO, v); check(v == wrOff, "R6", "RD_LO wrapped", v, wrOff);
    check(wrOff < 64, "R6", "offset wrapped small", wrOff, 0);

    // R10 stopped engine holds, R7 busy status
    hostWrite(A_CTRL, 0);
    hostRead(A_RD_LO, rdBefore);
    pushBurst('h0800, 3, 'h7000);
    commit();
    repeat (20) @(negedge clk);
    hostRead(A_RD_LO, v); check(v == rdBefore, "R10", "RD_LO while stopped", v, rdBefore);
    check(expQ.size() == 3, "R10", "writes held back", expQ.size(), 3);
    hostRead(A_STATUS, v); check(v == 'h8, "R7", "STATUS busy", v, 'h8);
    hostWrite(A_CTRL, 1);
    waitIdle("R10");
    check(expQ.size() == 0, "R10", "writes after restart", expQ.size(), 0);
    hostRead(A_STATUS, v); check(v == 'hC, "R7", "STATUS idle", v, 'hC);

    // R8 illegal header halts
    rdBefore = wrOff;
    emitWord(16'h1234); emitWord(16'h0000);
    commit();
    repeat (10) @(negedge clk);
    hostRead(A_STATUS, v); check(v == 0, "R8", "STATUS after failure", v, 0);
    hostRead(A_RD_LO, v); check(v == rdBefore, "R8", "RD_LO on bad word", v, rdBefore);
    doReset();
    @(negedge clk);
    hostRead(A_STATUS, v); check(v == 'hC, "R8", "STATUS after reset", v, 'hC);
    hostRead(A_RD_LO, v); check(v == 0, "R1", "RD_LO after reset", v, 0);

    finished = 1;
    summary();
  end

endmodule